// File: doc/BRIEF.md
# OSD Register Write Command Decoder

This block sits between a byte-level I2C slave front end and the register file of an on-screen display controller. The front end delivers each received byte as a one-cycle strobe, together with separate START and STOP indications. The decoder parses the byte stream and produces register write strobes. Each strobe carries a target space (display or attribute/control), a row, a column, a font page bit and eight data bits. It also answers a read request by returning a single status byte that holds the master-settable reset flag.

After the write slave address, the master can send a row byte followed by column/data pairs. It can also resend the row before every column, or switch to a streaming mode. In streaming mode, one row and one column are followed by any number of data bytes, and the address advances by itself. Tag bits in the row and column bytes choose between these formats. Once streaming begins, only a START or a STOP can end it.

Top module: `osd_cmd_decoder`

## Requirements
- R1: After reset, no write or read strobe is produced and the status byte reads 0x00. A reset clears a previously set flag.
- R2: The first byte after START is a slave address. 0x7A opens a write transaction. 0x7B produces exactly one `rdValid` pulse, in the cycle after the byte, with `rdData` = status byte (flag in bit 1, other bits 0), and all later bytes up to the next START are ignored. Any other address value makes every later byte be ignored.
- R3: A byte with bit 7 = 1 is a row byte: bit 5 selects the space (0 display, 1 attribute/control) and bits 3..0 the row. A byte with bit 7 = 0 is a column byte: bits 4..0 give the column, and bit 6 = 1 selects streaming.
- R4: In a column byte aimed at the display space, bit 5 becomes `wrPage` for the data that follows. In the attribute/control space, `wrPage` is 0.
- R5: A data byte that follows a non-streaming column byte produces one write strobe, in the cycle after the byte, using the latched space, row, column and page. Any byte in that position counts as data, whatever its bit 7. After the data, either a new column byte (pair format) or a new row byte (triple format) is accepted.
- R6: In streaming mode, every byte is written and the address then advances. For rows 0..14, column 29 is followed by column 0 of the next row. In row 15 the column counts up to 31 and holds there.
- R7: Once streaming is active, bytes with bit 7 set are still treated as data, until a START or a STOP arrives.
- R8: START makes the parser expect a slave address. STOP makes it ignore all bytes until the next START.
- R9: Writes to row 15, columns 24 and 31 of the attribute/control space produce no strobe. In streaming mode the address still advances past them.
- R10: A write to row 15, column 23 of the attribute/control space emits its strobe and also loads the status flag from data bit 1. The next read returns the new value.
- R11: Every strobe is one cycle wide, and each byte produces at most one strobe. A column byte received while a row byte is expected is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One-cycle strobe: a received byte is on byteData |
| byteData | input | 8 | Received byte |
| startSeen | input | 1 | One-cycle START (or repeated START) indication |
| stopSeen | input | 1 | One-cycle STOP indication |
| wrValid | output | 1 | Register write strobe |
| wrSpace | output | 1 | 0 display space, 1 attribute/control space |
| wrRow | output | 4 | Target row |
| wrCol | output | 5 | Target column |
| wrPage | output | 1 | Font page bit for display entries |
| wrData | output | 8 | Data byte to write |
| rdValid | output | 1 | Status byte is presented for transmission |
| rdData | output | 8 | Status byte |

## Verification
The hardest corner to reach from the ports is the top of the streaming address space. There, the row-15 column counter must skip two reserved columns, pass the flag column, and then saturate at 31 while data bytes keep arriving with bit 7 set. The stimulus reaches it by opening a stream at row 15, column 22 and sending eleven bytes. Those bytes cross the flag, both reserved columns and the saturation point, and include row-looking values. A later read then confirms that the flag captured the right byte.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 5;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ADDR,
    PS_ROW,
    PS_COL,
    PS_DATA,
    PS_STREAM
  } parseState_t;

  typedef struct packed {
    logic loadRow;
    logic loadCol;
    logic emit;
    logic advance;
    logic readOut;
  } ctlStrobes_t;
endpackage

// File: rtl/osd_cmd_ctrl.sv
module osd_cmd_ctrl
  import osd_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WR_ADDR = 8'h7A,
  parameter logic [BYTE_W-1:0] RD_ADDR = 8'h7B,
  parameter int ROW_TAG_BIT    = 7,
  parameter int STREAM_TAG_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              startSeen,
  input  logic              stopSeen,
  output ctlStrobes_t       ctl
);
  parseState_t state, stateNext;
  logic isRow;

  assign isRow = byteData[ROW_TAG_BIT];

  always_comb begin
    ctl       = '0;
    stateNext = state;
    if (startSeen) begin
      stateNext = PS_ADDR;
    end else if (stopSeen) begin
      stateNext = PS_IDLE;
    end else if (byteValid) begin
      case (state)
        PS_ADDR: begin
          if (byteData == WR_ADDR) begin
            stateNext = PS_ROW;
          end else if (byteData == RD_ADDR) begin
            ctl.readOut = 1'b1;
            stateNext   = PS_IDLE;
          end else begin
            stateNext = PS_IDLE;
          end
        end
        PS_ROW: begin
          if (isRow) begin
            ctl.loadRow = 1'b1;
            stateNext   = PS_COL;
          end
        end
        PS_COL: begin
          if (isRow) begin
            ctl.loadRow = 1'b1;
          end else begin
            ctl.loadCol = 1'b1;
            stateNext   = byteData[STREAM_TAG_BIT] ? PS_STREAM : PS_DATA;
          end
        end
        PS_DATA: begin
          ctl.emit  = 1'b1;
          stateNext = PS_COL;
        end
        PS_STREAM: begin
          ctl.emit    = 1'b1;
          ctl.advance = 1'b1;
        end
        default: stateNext = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PS_IDLE;
    else       state <= stateNext;
  end

  AST_STREAM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_STREAM && !startSeen && !stopSeen) |=> state == PS_STREAM); // R7
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> state == PS_ADDR); // R8
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !startSeen) |=> state == PS_IDLE); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.loadRow, ctl.loadCol, ctl.emit, ctl.readOut}) <= 1); // R11
endmodule

// File: rtl/osd_cmd_dpath.sv
module osd_cmd_dpath
  import osd_cmd_pkg::*;
#(
  parameter int COLS_MAIN = 30,
  parameter int CTRL_ROW  = 15,
  parameter int FLAG_COL  = 23,
  parameter int RSV_COL_A = 24,
  parameter int RSV_COL_B = 31,
  parameter int FLAG_BIT  = 1,
  parameter int SPACE_BIT = 5,
  parameter int PAGE_BIT  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteData,
  input  ctlStrobes_t       ctl,
  output logic              wrValid,
  output logic              wrSpace,
  output logic [ROW_W-1:0]  wrRow,
  output logic [COL_W-1:0]  wrCol,
  output logic              wrPage,
  output logic [BYTE_W-1:0] wrData,
  output logic              rdValid,
  output logic [BYTE_W-1:0] rdData
);
  localparam logic [ROW_W-1:0] CTRL_ROW_V = ROW_W'(CTRL_ROW);
  localparam logic [COL_W-1:0] COL_LAST   = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] COL_WRAP   = COL_W'(COLS_MAIN - 1);
  localparam logic [COL_W-1:0] FLAG_COL_V = COL_W'(FLAG_COL);
  localparam logic [COL_W-1:0] RSV_A_V    = COL_W'(RSV_COL_A);
  localparam logic [COL_W-1:0] RSV_B_V    = COL_W'(RSV_COL_B);

  logic             spaceQ, pageQ, flagQ;
  logic [ROW_W-1:0] rowQ, rowNext;
  logic [COL_W-1:0] colQ, colNext;
  logic             inCtrlRow, reservedHit, flagHit;
  logic [BYTE_W-1:0] statusByte;

  assign inCtrlRow   = spaceQ && (rowQ == CTRL_ROW_V);
  assign reservedHit = inCtrlRow && (colQ == RSV_A_V || colQ == RSV_B_V);
  assign flagHit     = inCtrlRow && (colQ == FLAG_COL_V);

  always_comb begin
    statusByte           = '0;
    statusByte[FLAG_BIT] = flagQ;
  end

  // Streaming address step: wrap inside the text rows, saturate in the control row
  always_comb begin
    rowNext = rowQ;
    colNext = colQ;
    if (rowQ == CTRL_ROW_V) begin
      if (colQ != COL_LAST) colNext = colQ + 1'b1;
    end else if (colQ == COL_WRAP) begin
      colNext = '0;
      rowNext = rowQ + 1'b1;
    end else begin
      colNext = colQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spaceQ  <= 1'b0;
      pageQ   <= 1'b0;
      rowQ    <= '0;
      colQ    <= '0;
      flagQ   <= 1'b0;
      wrValid <= 1'b0;
      wrSpace <= 1'b0;
      wrRow   <= '0;
      wrCol   <= '0;
      wrPage  <= 1'b0;
      wrData  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      wrValid <= ctl.emit && !reservedHit;
      rdValid <= ctl.readOut;
      if (ctl.readOut) rdData <= statusByte;
      if (ctl.loadRow) begin
        spaceQ <= byteData[SPACE_BIT];
        rowQ   <= byteData[ROW_W-1:0];
      end
      if (ctl.loadCol) begin
        colQ  <= byteData[COL_W-1:0];
        pageQ <= !spaceQ && byteData[PAGE_BIT];
      end
      if (ctl.emit) begin
        wrSpace <= spaceQ;
        wrRow   <= rowQ;
        wrCol   <= colQ;
        wrPage  <= pageQ;
        wrData  <= byteData;
        if (flagHit) flagQ <= byteData[FLAG_BIT];
      end
      if (ctl.advance) begin
        rowQ <= rowNext;
        colQ <= colNext;
      end
    end
  end

  AST_NO_RESERVED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSpace && wrRow == CTRL_ROW_V) |-> (wrCol != RSV_A_V && wrCol != RSV_B_V)); // R9
  AST_ATTR_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSpace) |-> !wrPage); // R4
  AST_CTRL_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && rowQ == CTRL_ROW_V && colQ == COL_LAST) |=> (rowQ == CTRL_ROW_V && colQ == COL_LAST)); // R6
  AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($countones(rdData) <= 1)); // R2
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WR_ADDR = 8'h7A,
  parameter logic [BYTE_W-1:0] RD_ADDR = 8'h7B,
  parameter int COLS_MAIN = 30,
  parameter int CTRL_ROW  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              startSeen,
  input  logic              stopSeen,
  output logic              wrValid,
  output logic              wrSpace,
  output logic [3:0]        wrRow,
  output logic [4:0]        wrCol,
  output logic              wrPage,
  output logic [7:0]        wrData,
  output logic              rdValid,
  output logic [7:0]        rdData
);
  ctlStrobes_t ctl;

  osd_cmd_ctrl #(
    .WR_ADDR(WR_ADDR),
    .RD_ADDR(RD_ADDR)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .byteValid(byteValid),
    .byteData(byteData),
    .startSeen(startSeen),
    .stopSeen(stopSeen),
    .ctl(ctl)
  );

  osd_cmd_dpath #(
    .COLS_MAIN(COLS_MAIN),
    .CTRL_ROW(CTRL_ROW)
  ) uDpath (
    .clk(clk),
    .rstN(rstN),
    .byteData(byteData),
    .ctl(ctl),
    .wrValid(wrValid),
    .wrSpace(wrSpace),
    .wrRow(wrRow),
    .wrCol(wrCol),
    .wrPage(wrPage),
    .wrData(wrData),
    .rdValid(rdValid),
    .rdData(rdData)
  );

  AST_WR_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(byteValid)); // R11
  AST_RD_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(byteValid) && $past(byteData) == RD_ADDR)); // R2
  AST_NO_WR_AND_RD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && rdValid)); // R11
endmodule

// File: tb/tb_osd_cmd_decoder.sv
module tb_osd_cmd_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic startSeen = 1'b0;
  logic stopSeen = 1'b0;
  logic wrValid, wrSpace, wrPage, rdValid;
  logic [3:0] wrRow;
  logic [4:0] wrCol;
  logic [7:0] wrData, rdData;

  always #4 clk = ~clk;

  osd_cmd_decoder dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .wrValid(wrValid), .wrSpace(wrSpace), .wrRow(wrRow), .wrCol(wrCol),
    .wrPage(wrPage), .wrData(wrData), .rdValid(rdValid), .rdData(rdData)
  );

  typedef struct {
    bit isRead;
    bit space;
    int row;
    int col;
    bit page;
    int data;
    string req;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  bit done = 0;

  task automatic expWr(bit s, int r, int c, bit p, int d, string req);
    item_t it;
    it.isRead = 0; it.space = s; it.row = r; it.col = c; it.page = p; it.data = d; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic expRd(int d, string req);
    item_t it;
    it.isRead = 1; it.space = 0; it.row = 0; it.col = 0; it.page = 0; it.data = d; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteData = b;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic doStart();
    @(negedge clk); startSeen = 1'b1;
    @(negedge clk); startSeen = 1'b0;
  endtask

  task automatic doStop();
    @(negedge clk); stopSeen = 1'b1;
    @(negedge clk); stopSeen = 1'b0;
  endtask

  task automatic drained(string req);
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected strobes missing (expected 0)", req, expQ.size());
      expQ.delete();
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && (wrValid || rdValid)) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected %s strobe data=%02h (expected none)", curReq,
                 wrValid ? "write" : "read", wrValid ? wrData : rdData);
      end else begin
        item_t e;
        e = expQ.pop_front();
        if (wrValid) begin
          if (e.isRead || wrRvalid(e) == 0) begin
            fails++;
            $display("FAIL %s: write sp=%0d row=%0d col=%0d pg=%0d d=%02h expected rd=%0d sp=%0d row=%0d col=%0d pg=%0d d=%02h",
                     e.req, wrSpace, wrRow, wrCol, wrPage, wrData, e.isRead, e.space, e.row, e.col, e.page, e.data);
          end
        end else begin
          if (!e.isRead || rdData != 8'(e.data)) begin
            fails++;
            $display("FAIL %s: read data=%02h expected rd=%0d data=%02h", e.req, rdData, e.isRead, e.data);
          end
        end
      end
    end
  end

  function automatic bit wrRvalid(item_t e);
    return wrSpace == e.space && int'(wrRow) == e.row && int'(wrCol) == e.col &&
           wrPage == e.page && int'(wrData) == e.data;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung (expected completion)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (wrValid !== 1'b0 || rdValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: wrValid=%b rdValid=%b expected 0 0", wrValid, rdValid);
    end
    curReq = "R1";
    doStart(); expRd(8'h00, "R1"); sendByte(8'h7B); drained("R1");

    // Pair and triple formats, page bit
    curReq = "R5";
    doStart(); sendByte(8'h7A);
    sendByte(8'h83);
    sendByte(8'h25); expWr(0, 3, 5, 1, 8'h41, "R4"); sendByte(8'h41);
    sendByte(8'h06); expWr(0, 3, 6, 0, 8'h9F, "R5"); sendByte(8'h9F);
    sendByte(8'hA2); sendByte(8'h21); expWr(1, 2, 1, 0, 8'h43, "R4"); sendByte(8'h43);
    sendByte(8'hA4); sendByte(8'h4A);
    expWr(1, 4, 10, 0, 8'h55, "R3"); sendByte(8'h55);
    expWr(1, 4, 11, 0, 8'h66, "R6"); sendByte(8'h66);
    doStop(); drained("R5");

    // Column byte while a row is expected is dropped
    curReq = "R11";
    doStart(); sendByte(8'h7A); sendByte(8'h05);
    sendByte(8'h85); sendByte(8'h02); expWr(0, 5, 2, 0, 8'h11, "R11"); sendByte(8'h11);
    doStop(); drained("R11");

    // Stream wrap in text rows, page carried
    curReq = "R6";
    doStart(); sendByte(8'h7A); sendByte(8'hA0); sendByte(8'h5C);
    expWr(1, 0, 28, 0, 8'hC1, "R6"); sendByte(8'hC1);
    expWr(1, 0, 29, 0, 8'hC2, "R6"); sendByte(8'hC2);
    expWr(1, 1, 0, 0, 8'hC3, "R6"); sendByte(8'hC3);
    doStart(); sendByte(8'h7A); sendByte(8'h8E); sendByte(8'h7D);
    expWr(0, 14, 29, 1, 8'h10, "R6"); sendByte(8'h10);
    expWr(0, 15, 0, 1, 8'h11, "R6"); sendByte(8'h11);
    doStop(); drained("R6");

    // Control-row stream: flag, reserved columns, saturation, row-looking data
    curReq = "R9";
    doStart(); sendByte(8'h7A); sendByte(8'hAF); sendByte(8'h56);
    expWr(1, 15, 22, 0, 8'h11, "R6"); sendByte(8'h11);
    expWr(1, 15, 23, 0, 8'h02, "R10"); sendByte(8'h02);
    sendByte(8'h33);
    expWr(1, 15, 25, 0, 8'h91, "R7"); sendByte(8'h91);
    expWr(1, 15, 26, 0, 8'hA5, "R7"); sendByte(8'hA5);
    for (int c = 27; c <= 30; c++) begin
      expWr(1, 15, c, 0, c, "R6"); sendByte(8'(c));
    end
    sendByte(8'h0B); sendByte(8'h8C);
    doStop(); drained("R9");
    curReq = "R10";
    doStart(); expRd(8'h02, "R10"); sendByte(8'h7B);
    sendByte(8'h80); sendByte(8'h01); sendByte(8'h55);
    doStop(); drained("R2");

    // Reserved columns in pair format; flag cleared by write
    curReq = "R9";
    doStart(); sendByte(8'h7A); sendByte(8'hAF);
    sendByte(8'h18); sendByte(8'h77);
    sendByte(8'h1F); sendByte(8'h78);
    sendByte(8'h17); expWr(1, 15, 23, 0, 8'h00, "R10"); sendByte(8'h00);
    doStart(); expRd(8'h00, "R10"); sendByte(8'h7B); drained("R10");

    // Bad address ignored
    curReq = "R2";
    doStart(); sendByte(8'h50); sendByte(8'h81); sendByte(8'h02); sendByte(8'h33);
    drained("R2");

    // STOP and START reset the parser
    curReq = "R8";
    doStart(); sendByte(8'h7A); sendByte(8'h81); sendByte(8'h02); doStop();
    sendByte(8'h99); drained("R8");
    doStart(); sendByte(8'h7A); sendByte(8'h81); sendByte(8'h42);
    expWr(0, 1, 2, 0, 8'h01, "R8"); sendByte(8'h01);
    doStart(); sendByte(8'h81); sendByte(8'h44); drained("R8");
    doStart(); sendByte(8'h7A); sendByte(8'h85); sendByte(8'h03);
    expWr(0, 5, 3, 0, 8'h44, "R8"); sendByte(8'h44); doStop(); drained("R8");

    // Reset clears the flag
    curReq = "R1";
    doStart(); sendByte(8'h7A); sendByte(8'hAF); sendByte(8'h17);
    expWr(1, 15, 23, 0, 8'h02, "R10"); sendByte(8'h02); doStop(); drained("R10");
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    doStart(); expRd(8'h00, "R1"); sendByte(8'h7B); drained("R1");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule